// File: doc/BRIEF.md
# Two-Flag Arithmetic Unit with Compare

This block is a 32-bit arithmetic unit. It takes two operands and an operation code, and it returns a result word, a write-enable for that result and a two-bit condition register. The unit has five operations: add, subtract, compare, a one-place left shift and a one-place logical right shift. For compare, the flags change as they would for a subtract, but the write-enable stays low, so the caller's destination register is left as it was.

Each operation is committed on a clock edge where the valid strobe is high. The result, the write-enable and the flags all come from registers. The flags keep their value between strobes, so a later branch or test can read the condition left by the most recent operation. Register-file access, operand selection and branching are the caller's job.

The data width, the adder variant and the chunk width of the zero detector are parameters. Elaboration checks reject values that make no sense.

Top module: `alu_two_flag`

## Requirements
- R1: While reset is asserted, and right after it is released, `result_o` is 0, `flags_o` is 2'b00 and `wr_en_o` is 0.
- R2: The `op_i` codes are 0 add, 1 subtract, 2 shift left, 3 shift right and 4 compare. A strobe with code 5, 6 or 7 leaves the flags and the result unchanged and drives `wr_en_o` to 0.
- R3: Add returns `a_i + b_i` modulo 2^32. The carry is the unsigned carry out of bit 31.
- R4: Subtract returns `a_i - b_i` modulo 2^32. The carry is set exactly when `a_i < b_i` as unsigned numbers (a borrow).
- R5: Shift left returns `a_i` moved up one place with a 0 entering bit 0. The carry takes the old bit 31.
- R6: Shift right is logical. It returns `a_i` moved down one place with a 0 entering bit 31. The carry takes the old bit 0.
- R7: Compare sets both flags exactly as subtract would, and `result_o` shows the difference. `wr_en_o` stays 0.
- R8: For every legal operation the zero flag is set when the 32-bit result is 0, and cleared otherwise.
- R9: `flags_o[0]` is the zero flag and `flags_o[1]` is the carry flag.
- R10: A cycle with `valid_i` low leaves `flags_o` and `result_o` unchanged, and `wr_en_o` reads 0 after that edge, whatever the other inputs are.
- R11: All outputs are registered. An operation strobed at one edge shows on the outputs right after that edge. `wr_en_o` is high for exactly one cycle for each strobed add, subtract or shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that commits the operation on this edge |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (add, subtract, compare) |
| result_o | output | 32 | Registered result of the last legal operation |
| wr_en_o | output | 1 | One-cycle result write-enable, low for compare |
| flags_o | output | 2 | Condition flags: bit 1 carry, bit 0 zero |

## Verification
The bench builds the unit with its default parameters: 32-bit data, the shared inverting adder and an 8-bit chunked zero tree. Because the data is 32 bits wide, the operand patterns can reach the real boundary bits. These include all-ones plus one, which wraps to zero with a carry, and bit 31 or bit 0 set when they are shifted out. Zero sums, zero differences and zero shift results also pass through every chunk of the zero tree. The shared adder is covered in both of its modes, including the borrow edge where the subtrahend is larger than the minuend.

// File: rtl/alu_two_flag_pkg.sv
package alu_two_flag_pkg;

   localparam int OP_W   = 3;
   localparam int FLAG_W = 2;
   localparam int FLAG_Z = 0;
   localparam int FLAG_C = 1;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_SHL = 3'd2,
      OP_SHR = 3'd3,
      OP_CMP = 3'd4
   } alu_op_e;

   function automatic logic op_legal(input logic [OP_W-1:0] code);
      return code <= 3'd4;
   endfunction

   function automatic logic op_writes(input logic [OP_W-1:0] code);
      return (code <= 3'd3);
   endfunction

   function automatic logic op_subtracts(input logic [OP_W-1:0] code);
      return (code == 3'd1) || (code == 3'd4);
   endfunction

endpackage

// File: rtl/alu_two_flag_addsub.sv
module alu_two_flag_addsub #(
   parameter int W      = 32,
   parameter int SHARED = 1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output logic         carry_o
);

   generate
      if (SHARED != 0 && SHARED != 1) begin : g_bad_shared
         $error("alu_two_flag_addsub: SHARED must be 0 or 1");
      end

      if (SHARED == 1) begin : g_shared
         // one adder: subtract = a + ~b + 1, borrow = no carry out
         logic [W-1:0] b_eff;
         logic [W:0]   sum_ext;
         always_comb begin
            b_eff   = sub_i ? ~b_i : b_i;
            sum_ext = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
            res_o   = sum_ext[W-1:0];
            carry_o = sub_i ? ~sum_ext[W] : sum_ext[W];
         end
      end else begin : g_split
         logic [W:0] add_ext;
         logic [W:0] sub_ext;
         always_comb begin
            add_ext = {1'b0, a_i} + {1'b0, b_i};
            sub_ext = {1'b0, a_i} - {1'b0, b_i};
            res_o   = sub_i ? sub_ext[W-1:0] : add_ext[W-1:0];
            carry_o = sub_i ? sub_ext[W] : add_ext[W];
         end
      end
   endgenerate

endmodule

// File: rtl/alu_two_flag_shift1.sv
module alu_two_flag_shift1 #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic         left_i,
   output logic [W-1:0] res_o,
   output logic         carry_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("alu_two_flag_shift1: W must be at least 2");
      end
   endgenerate

   always_comb begin
      if (left_i) begin
         res_o   = {a_i[W-2:0], 1'b0};
         carry_o = a_i[W-1];
      end else begin
         res_o   = {1'b0, a_i[W-1:1]};
         carry_o = a_i[0];
      end
   end

endmodule

// File: rtl/alu_two_flag_zero.sv
module alu_two_flag_zero #(
   parameter int W       = 32,
   parameter int CHUNK_W = 8
) (
   input  logic [W-1:0] data_i,
   output logic         zero_o
);

   localparam int NCHUNK = (W + CHUNK_W - 1) / CHUNK_W;
   localparam int PAD_W  = NCHUNK * CHUNK_W;

   generate
      if (CHUNK_W < 1 || CHUNK_W > W) begin : g_bad_chunk
         $error("alu_two_flag_zero: CHUNK_W must lie in 1..W");
      end
   endgenerate

   logic [PAD_W-1:0]  padded;
   logic [NCHUNK-1:0] chunk_nz;

   assign padded = PAD_W'(data_i);

   generate
      for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
         assign chunk_nz[i] = |padded[i*CHUNK_W +: CHUNK_W];
      end
   endgenerate

   assign zero_o = ~|chunk_nz;

endmodule

// File: rtl/alu_two_flag.sv
module alu_two_flag
   import alu_two_flag_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int SHARED_ADDER = 1,
   parameter int ZERO_CHUNK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic [FLAG_W-1:0] flags_o
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("alu_two_flag: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] as_res;
   logic              as_carry;
   logic [DATA_W-1:0] sh_res;
   logic              sh_carry;
   logic [DATA_W-1:0] nxt_res;
   logic              nxt_carry;
   logic              nxt_zero;
   logic              is_sub;
   logic              is_shift;
   logic              commit;

   assign is_sub   = op_subtracts(op_i);
   assign is_shift = (op_i == OP_SHL) || (op_i == OP_SHR);
   assign commit   = valid_i && op_legal(op_i);

   alu_two_flag_addsub #(
      .W      (DATA_W),
      .SHARED (SHARED_ADDER)
   ) u_addsub (
      .a_i     (a_i),
      .b_i     (b_i),
      .sub_i   (is_sub),
      .res_o   (as_res),
      .carry_o (as_carry)
   );

   alu_two_flag_shift1 #(
      .W (DATA_W)
   ) u_shift (
      .a_i     (a_i),
      .left_i  (op_i == OP_SHL),
      .res_o   (sh_res),
      .carry_o (sh_carry)
   );

   always_comb begin
      nxt_res   = is_shift ? sh_res   : as_res;
      nxt_carry = is_shift ? sh_carry : as_carry;
   end

   alu_two_flag_zero #(
      .W       (DATA_W),
      .CHUNK_W (ZERO_CHUNK_W)
   ) u_zero (
      .data_i (nxt_res),
      .zero_o (nxt_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         flags_o  <= '0;
         wr_en_o  <= 1'b0;
      end else begin
         wr_en_o <= commit && op_writes(op_i);
         if (commit) begin
            result_o        <= nxt_res;
            flags_o[FLAG_C] <= nxt_carry;
            flags_o[FLAG_Z] <= nxt_zero;
         end
      end
   end

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(flags_o) && $stable(result_o));  // R10

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !wr_en_o);  // R10

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == OP_CMP) |=> !wr_en_o);  // R7

   AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !op_legal(op_i)) |=> $stable(flags_o) && !wr_en_o);  // R2

   AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_legal(op_i)) |=> flags_o[FLAG_Z] == (result_o == '0));  // R8

   AST_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && is_sub) |=> flags_o[FLAG_C] == ($past(a_i) < $past(b_i)));  // R4

   AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == OP_SHL) |=> flags_o[FLAG_C] == $past(a_i[MSB]));  // R5

   AST_SHR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == OP_SHR) |=> flags_o[FLAG_C] == $past(a_i[0]));  // R6

   AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_writes(op_i)) |=> wr_en_o);  // R11

endmodule

// File: tb/alu_two_flag_test.sv
module alu_two_flag_test;

   localparam int NVEC = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [31:0] a_i = '0;
   logic [31:0] b_i = '0;
   logic [31:0] result_o;
   logic        wr_en_o;
   logic [1:0]  flags_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   alu_two_flag uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (valid_i),
      .op_i     (op_i),
      .a_i      (a_i),
      .b_i      (b_i),
      .result_o (result_o),
      .wr_en_o  (wr_en_o),
      .flags_o  (flags_o)
   );

   // {op, a, b, result, flags(carry,zero), wr_en}
   localparam logic [101:0] VEC [NVEC] = '{
      {3'd0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 2'b00, 1'b1},
      {3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 2'b11, 1'b1},
      {3'd0, 32'h8000_0000, 32'h8000_0001, 32'h0000_0001, 2'b10, 1'b1},
      {3'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 2'b01, 1'b1},
      {3'd1, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 2'b01, 1'b1},
      {3'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 2'b10, 1'b1},
      {3'd1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 1'b1},
      {3'd1, 32'h1234_5678, 32'h0000_0678, 32'h1234_5000, 2'b00, 1'b1},
      {3'd2, 32'h8000_0001, 32'h0000_0000, 32'h0000_0002, 2'b10, 1'b1},
      {3'd2, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 2'b11, 1'b1},
      {3'd2, 32'h4000_0000, 32'h0000_0000, 32'h8000_0000, 2'b00, 1'b1},
      {3'd3, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 2'b11, 1'b1},
      {3'd3, 32'h8000_0000, 32'h0000_0000, 32'h4000_0000, 2'b00, 1'b1},
      {3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 32'h7FFF_FFFF, 2'b10, 1'b1},
      {3'd4, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000, 2'b01, 1'b0},
      {3'd4, 32'h0000_0002, 32'h0000_0009, 32'hFFFF_FFF9, 2'b10, 1'b0}
   };

   function automatic string op_req(input logic [2:0] code);
      case (code)
         3'd0:    return "R3";
         3'd1:    return "R4";
         3'd2:    return "R5";
         3'd3:    return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL R11 watchdog: actual %0d cycles expected fewer than 20000", cycles);
         summary();
         $finish;
      end
   end

   task automatic drive(input logic v, input logic [2:0] op,
                        input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      valid_i = v;
      op_i    = op;
      a_i     = a;
      b_i     = b;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check("R1", "result in reset", result_o, 32'h0);
      check("R1", "flags in reset", {30'd0, flags_o}, 32'h0);
      check("R1", "wr_en in reset", {31'd0, wr_en_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "flags after release", {30'd0, flags_o}, 32'h0);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         drive(1'b1, VEC[i][101:99], VEC[i][98:67], VEC[i][66:35]);
         @(negedge clk);
         check(op_req(VEC[i][101:99]), "result", result_o, VEC[i][34:3]);
         check("R8", "flags", {30'd0, flags_o}, {30'd0, VEC[i][2:1]});
         check(VEC[i][101:99] == 3'd4 ? "R7" : "R11", "wr_en",
               {31'd0, wr_en_o}, {31'd0, VEC[i][0]});
         valid_i = 1'b0;
      end

      // R9: carry lands in bit 1, zero in bit 0
      drive(1'b1, 3'd1, 32'h0000_0001, 32'h0000_0002);
      @(negedge clk);
      check("R9", "carry bit position", {31'd0, flags_o[1]}, 32'h1);
      check("R9", "zero bit position", {31'd0, flags_o[0]}, 32'h0);

      // R10: idle cycle with active-looking inputs holds everything
      drive(1'b0, 3'd0, 32'h0000_0000, 32'h0000_0000);
      @(negedge clk);
      check("R10", "result held", result_o, 32'hFFFF_FFFF);
      check("R10", "flags held", {30'd0, flags_o}, 32'h2);
      check("R11", "wr_en single pulse", {31'd0, wr_en_o}, 32'h0);

      // R2: illegal codes ignored
      drive(1'b1, 3'd0, 32'h0000_0005, 32'h0000_0005);
      @(negedge clk);
      for (int c = 5; c < 8; c++) begin
         drive(1'b1, 3'(c), 32'hFFFF_FFFF, 32'h0000_0001);
         @(negedge clk);
         check("R2", "result after illegal op", result_o, 32'h0000_000A);
         check("R2", "flags after illegal op", {30'd0, flags_o}, 32'h0);
         check("R2", "wr_en after illegal op", {31'd0, wr_en_o}, 32'h0);
      end
      valid_i = 1'b0;

      // R7: compare leaves the carry set by a borrow while wr_en stays low
      drive(1'b1, 3'd4, 32'h0000_0001, 32'hFFFF_FFFF);
      @(negedge clk);
      check("R7", "cmp flags", {30'd0, flags_o}, 32'h2);
      check("R7", "cmp no write", {31'd0, wr_en_o}, 32'h0);
      valid_i = 1'b0;

      // R1: reset in the middle of a run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "result after mid reset", result_o, 32'h0);
      check("R1", "flags after mid reset", {30'd0, flags_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      summary();
      $finish;
   end

endmodule